// File: doc/BRIEF.md
# Flash Busy-Status Read Generator

This block shapes the byte that a flash bank model hands back to a host read while an internal program or erase job is running. The status travels inside the data itself. Bit 7 is a polling flag. While a byte is being programmed it shows the complement of that byte's top bit, and while an erase runs it shows 0. Bit 6 is a toggle flag that flips once per read access for as long as the job runs. Reads only see status once the command has delivered enough write-enable pulses. Before that point, and whenever the bank is idle, reads pass the stored array byte through unchanged.

When a program job finishes, the polling bit is correct at once, but the lower bits are only guaranteed after a settling interval. That interval is set in clock cycles by a parameter. During it the block drives deliberately unreliable low bits and holds its ready flag low. An erase that finishes needs no settling. The host-side command decoder supplies the busy flag, the job type, the pulse count and the target byte. The array supplies the stored byte at the read address.

Top module: `flash_status_gen`

## Requirements
- R1: While status is shown for a program job, bit 7 of `rdData` equals the inverse of `progData[7]`, and bits 5..0 equal `arrayData[5:0]`.
- R2: While status is shown for an erase job (`opIsErase`=1), bit 7 of `rdData` is 0.
- R3: While status is shown, bit 6 of `rdData` shows a toggle flag. The flag flips at the first clock edge that sees `rdStrobe` high after it was low. A strobe held high over many clocks counts as one read.
- R4: Status is shown only when `busy`=1 and `wePulseCount` is at least 4 for a program job or at least 6 for an erase job. Below that count, `rdData` equals `arrayData`.
- R5: With `busy`=0 and no settling in progress, `rdData` equals `arrayData`. Strobes in that state leave the toggle flag unchanged, which is seen on the next status read.
- R6: After `busy` falls at the end of a program job, the bank settles for SETTLE_CYCLES clock cycles, counting the first cycle with `busy` low. During that time `rdData` is `{arrayData[7], ~arrayData[6:0]}`.
- R7: `ready` is 0 whenever `busy` is 1 or settling is in progress, and 1 otherwise. The end of an erase job sets `ready` in the first cycle with `busy` low.
- R8: A synchronous reset `rst` clears the toggle flag to 0 and ends any settling, so that `ready` is 1 right after reset when `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busy | input | 1 | Internal program or erase job running |
| opIsErase | input | 1 | 1 for an erase job, 0 for a program job |
| progData | input | 8 | Byte being programmed |
| arrayData | input | 8 | Stored array byte at the read address |
| rdStrobe | input | 1 | Host read access, high for the length of the read |
| wePulseCount | input | CNT_W | Write-enable pulses seen in the current command |
| rdData | output | 8 | Byte returned to the host |
| ready | output | 1 | Bank ready, full byte valid |

## Verification
A read strobe can rise in the same cycle that busy falls, so the toggle update and the start of settling fall in the same cycle. The bench produces this by raising the strobe at the very edge where a program job ends. It then checks that the toggle flag does not advance, since the job is over and status is no longer shown. In the same run it checks that `rdData` carries the settling pattern and that `ready` stays low for exactly the configured number of cycles. A second pairing uses the pulse-count threshold: the count crosses the threshold while a strobe is held high. The bench checks that the crossing starts status display without producing an extra toggle.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic statusOn;    // status replaces array data
    logic settling;    // post-program settling window
    logic flipToggle;  // advance toggle flag this cycle
  } rdCtrl_t;
endpackage

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import flash_status_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int PROG_PULSES = 4,
  parameter int ERASE_PULSES = 6,
  parameter int SETTLE_CYCLES = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             opIsErase,
  input  logic             rdStrobe,
  input  logic [CNT_W-1:0] wePulseCount,
  output rdCtrl_t          strobes,
  output logic             ready
);
  localparam int SW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] PROG_THR = CNT_W'(PROG_PULSES);
  localparam logic [CNT_W-1:0] ERASE_THR = CNT_W'(ERASE_PULSES);
  localparam logic [SW-1:0] SETTLE_LOAD = SW'(SETTLE_CYCLES - 1);

  logic          rdPrev;
  logic          busyPrev;
  logic          progLatched;
  logic [SW-1:0] settleCnt;
  logic          pulsesOk;
  logic          progEnd;

  assign pulsesOk = opIsErase ? (wePulseCount >= ERASE_THR) : (wePulseCount >= PROG_THR);
  assign progEnd  = busyPrev && progLatched && !busy;

  always_ff @(posedge clk) rdPrev <= rdStrobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      busyPrev    <= 1'b0;
      progLatched <= 1'b0;
      settleCnt   <= '0;
    end else begin
      busyPrev <= busy;
      if (busy) progLatched <= !opIsErase;
      if (busy)                  settleCnt <= '0;
      else if (progEnd)          settleCnt <= SETTLE_LOAD;
      else if (settleCnt != '0)  settleCnt <= settleCnt - 1'b1;
    end
  end

  always_comb begin
    strobes.statusOn   = busy && pulsesOk;
    strobes.settling   = progEnd || (settleCnt != '0);
    strobes.flipToggle = strobes.statusOn && rdStrobe && !rdPrev;
  end

  assign ready = !busy && !strobes.settling;
endmodule

// File: rtl/flash_status_dp.sv
module flash_status_dp
  import flash_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rdCtrl_t    strobes,
  input  logic       opIsErase,
  input  logic [7:0] progData,
  input  logic [7:0] arrayData,
  output logic [7:0] rdData,
  output logic       toggleQ
);
  always_ff @(posedge clk) begin
    if (rst)                     toggleQ <= 1'b0;
    else if (strobes.flipToggle) toggleQ <= !toggleQ;
  end

  always_comb begin
    if (strobes.statusOn)
      rdData = {(opIsErase ? 1'b0 : !progData[7]), toggleQ, arrayData[5:0]};
    else if (strobes.settling)
      rdData = {arrayData[7], ~arrayData[6:0]};
    else
      rdData = arrayData;
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int PROG_PULSES = 4,
  parameter int ERASE_PULSES = 6,
  parameter int SETTLE_CYCLES = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             opIsErase,
  input  logic [7:0]       progData,
  input  logic [7:0]       arrayData,
  input  logic             rdStrobe,
  input  logic [CNT_W-1:0] wePulseCount,
  output logic [7:0]       rdData,
  output logic             ready
);
  rdCtrl_t strobes;
  logic    toggleQ;
  logic    statusOnW;

  assign statusOnW = strobes.statusOn;

  flash_status_ctrl #(
    .CNT_W(CNT_W), .PROG_PULSES(PROG_PULSES),
    .ERASE_PULSES(ERASE_PULSES), .SETTLE_CYCLES(SETTLE_CYCLES)
  ) uCtrl (
    .clk(clk), .rst(rst), .busy(busy), .opIsErase(opIsErase),
    .rdStrobe(rdStrobe), .wePulseCount(wePulseCount),
    .strobes(strobes), .ready(ready)
  );

  flash_status_dp uDp (
    .clk(clk), .rst(rst), .strobes(strobes), .opIsErase(opIsErase),
    .progData(progData), .arrayData(arrayData),
    .rdData(rdData), .toggleQ(toggleQ)
  );
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             opIsErase,
  input logic [7:0]       progData,
  input logic [7:0]       arrayData,
  input logic             rdStrobe,
  input logic [CNT_W-1:0] wePulseCount,
  input logic [7:0]       rdData,
  input logic             ready,
  input logic             toggleQ,
  input logic             statusOn
);
  assert_prog_poll_R1: assert property (@(posedge clk) disable iff (rst)
    (statusOn && !opIsErase) |-> (rdData[7] == !progData[7]));

  assert_erase_poll_R2: assert property (@(posedge clk) disable iff (rst)
    (statusOn && opIsErase) |-> (rdData[7] == 1'b0));

  assert_held_read_once_R3: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && $past(rdStrobe)) |=> $stable(toggleQ));

  assert_array_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !statusOn) |-> (rdData == arrayData));

  assert_idle_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(toggleQ));

  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ready);
endmodule

bind flash_status_gen flash_status_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rst(rst), .busy(busy), .opIsErase(opIsErase),
  .progData(progData), .arrayData(arrayData), .rdStrobe(rdStrobe),
  .wePulseCount(wePulseCount), .rdData(rdData), .ready(ready),
  .toggleQ(toggleQ), .statusOn(statusOnW)
);

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;
  localparam int CNT_W = 3;
  localparam int S = 5;

  logic clk = 1'b0;
  logic rst, busy, opIsErase, rdStrobe;
  logic [7:0] progData, arrayData, rdData;
  logic [CNT_W-1:0] wePulseCount;
  logic ready;

  int checks = 0;
  int failures = 0;
  logic expTog = 1'b0;

  always #10 clk = !clk;

  flash_status_gen #(.CNT_W(CNT_W), .PROG_PULSES(4), .ERASE_PULSES(6), .SETTLE_CYCLES(S)) u0 (
    .clk(clk), .rst(rst), .busy(busy), .opIsErase(opIsErase),
    .progData(progData), .arrayData(arrayData), .rdStrobe(rdStrobe),
    .wePulseCount(wePulseCount), .rdData(rdData), .ready(ready)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic progBusy();
    busy = 1'b1; opIsErase = 1'b0; wePulseCount = 3'd4;
  endtask

  initial begin
    #3_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; busy = 1'b0; opIsErase = 1'b0; rdStrobe = 1'b0;
    progData = 8'h00; arrayData = 8'hA5; wePulseCount = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #5;
    chk("R8 ready after reset", {7'd0, ready}, 8'd1);
    chk("R5 idle passthrough", rdData, 8'hA5);
    @(negedge clk);

    // R1: sweep every target byte
    progBusy();
    for (int v = 0; v < 256; v++) begin
      progData = 8'(v); arrayData = 8'(v) ^ 8'h3C;
      #5;
      chk("R1 poll bit", {7'd0, rdData[7]}, {7'd0, !progData[7]});
      chk("R1 low bits", {2'd0, rdData[5:0]}, {2'd0, arrayData[5:0]});
      chk("R7 busy not ready", {7'd0, ready}, 8'd0);
      @(negedge clk);
    end

    // R3: toggling, held strobe counted once
    for (int i = 0; i < 8; i++) begin
      rdStrobe = 1'b1; #5;
      chk("R3 toggle before edge", {7'd0, rdData[6]}, {7'd0, expTog});
      @(negedge clk); expTog = !expTog;
      repeat (3) @(negedge clk);
      #5 chk("R3 held strobe once", {7'd0, rdData[6]}, {7'd0, expTog});
      @(negedge clk); rdStrobe = 1'b0;
      @(negedge clk);
    end

    // R4 / R2: threshold sweep for both job types
    for (int op = 0; op < 2; op++) begin
      for (int c = 0; c < 8; c++) begin
        busy = 1'b1; opIsErase = op[0]; wePulseCount = CNT_W'(c);
        progData = 8'h80; arrayData = 8'(8'h96 + c);
        #5;
        if (c >= (op == 1 ? 6 : 4)) begin
          chk(op == 1 ? "R2 erase poll" : "R4 prog status", {7'd0, rdData[7]}, 8'd0);
          chk("R4 status toggle", {7'd0, rdData[6]}, {7'd0, expTog});
        end else begin
          chk("R4 below threshold", rdData, arrayData);
        end
        @(negedge clk);
      end
    end

    // R4: count crosses threshold while strobe held -> no extra toggle
    busy = 1'b1; opIsErase = 1'b0; wePulseCount = 3'd3; rdStrobe = 1'b1;
    @(negedge clk); @(negedge clk);
    wePulseCount = 3'd4;
    @(negedge clk); @(negedge clk);
    #5 chk("R4 crossing no toggle", {7'd0, rdData[6]}, {7'd0, expTog});
    @(negedge clk); rdStrobe = 1'b0; @(negedge clk);

    // R7: erase end gives ready at once
    busy = 1'b1; opIsErase = 1'b1; wePulseCount = 3'd6; arrayData = 8'hFF;
    @(negedge clk);
    busy = 1'b0; #5;
    chk("R7 erase end ready", {7'd0, ready}, 8'd1);
    chk("R5 after erase data", rdData, 8'hFF);
    @(negedge clk);

    // R5: idle strobes leave toggle frozen
    arrayData = 8'h5B;
    for (int i = 0; i < 3; i++) begin
      rdStrobe = 1'b1; #5;
      chk("R5 idle passthrough", rdData, 8'h5B);
      @(negedge clk); rdStrobe = 1'b0; @(negedge clk);
    end
    progBusy(); progData = 8'h00; #5;
    chk("R5 toggle frozen", {7'd0, rdData[6]}, {7'd0, expTog});
    @(negedge clk);

    // R6: settling after program end, strobe rising at the same edge
    arrayData = 8'hC3;
    busy = 1'b0; rdStrobe = 1'b1;
    for (int i = 0; i < S + 2; i++) begin
      #5;
      if (i < S) begin
        chk("R6 settling data", rdData, {arrayData[7], ~arrayData[6:0]});
        chk("R7 settling not ready", {7'd0, ready}, 8'd0);
      end else begin
        chk("R6 settled data", rdData, arrayData);
        chk("R7 ready after settle", {7'd0, ready}, 8'd1);
      end
      @(negedge clk);
    end
    rdStrobe = 1'b0; @(negedge clk);
    progBusy(); #5;
    chk("R3 no toggle at job end", {7'd0, rdData[6]}, {7'd0, expTog});
    @(negedge clk);

    // R8: reset mid-settling and toggle cleared
    if (!expTog) begin
      rdStrobe = 1'b1; @(negedge clk); rdStrobe = 1'b0; expTog = 1'b1; @(negedge clk);
    end
    busy = 1'b0; @(negedge clk);
    rst = 1'b1; @(negedge clk); rst = 1'b0; #5;
    chk("R8 reset ends settling", {7'd0, ready}, 8'd1);
    chk("R8 reset data", rdData, arrayData);
    @(negedge clk);
    progBusy(); expTog = 1'b0; #5;
    chk("R8 toggle cleared", {7'd0, rdData[6]}, 8'd0);
    @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule